// File: doc/BRIEF.md
# Single-Level Call/Return Page Sequencer

This block drives program addressing for a small 4-bit controller. It keeps a program counter inside the current page, a current-page register, a staging page register (the "page buffer") and a single saved return address. It also keeps a call-active latch and a one-shot condition flag. Each clock cycle is one instruction. The surrounding decoder presents that instruction's control strobes, and the block picks the next program counter and page.

A far jump works in two steps. A load-page instruction first stages a page number in the buffer. A taken branch then moves the staged page into the current page. A taken call swaps the two page registers, so the caller's page is parked in the buffer until the return. Only one return level exists. A second call made before the return overwrites the parked page with the callee's page in a defined way, and the later return lands in the wrong page. No data stream passes through the block, so there is no valid/ready handshake. Every pin is a plain per-cycle control or status line, sampled on each rising clock edge.

Top module: `cr_page_seq`

## Requirements
- R1: Synchronous active-high reset sets the program counter, current page, page buffer, saved return address and call latch to zero, and sets the condition flag to one.
- R2: In a cycle where no return, call or branch is taken, the program counter advances by one and wraps from 63 to 0, and the current page keeps its value.
- R3: A clear request in one cycle makes the condition flag read zero in the next cycle only. The flag reads one again in the cycle after that, unless the clear is repeated.
- R4: A branch or call strobe in a cycle whose condition flag is zero has no effect: the program counter advances by one and no page register, return address or call latch changes.
- R5: A taken branch with the call latch clear loads the 6-bit branch field into the program counter and copies the page buffer into the current page.
- R6: A taken branch with the call latch set loads the branch field into the program counter and leaves the current page unchanged.
- R7: A taken call with the call latch clear swaps the current page and the page buffer in the same edge, saves the call's address plus one (mod 64) as the return address, loads the branch field into the program counter and sets the call latch.
- R8: A return, regardless of the condition flag, loads the saved return address into the program counter, copies the page buffer into the current page and clears the call latch.
- R9: A taken call with the call latch already set copies the current page into the page buffer. It keeps the current page and the saved return address, and still loads the branch field into the program counter.
- R10: A load-page strobe writes the 4-bit page constant into the page buffer only. It is ignored in a cycle where a call is taken.
- R11: When several strobes are high together, a return wins over a call and a call wins over a branch. A strobe that loses is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one instruction per cycle |
| rst | input | 1 | Synchronous active-high reset |
| br_req | input | 1 | Conditional branch strobe |
| call_req | input | 1 | Conditional call strobe |
| ret_req | input | 1 | Return strobe (unconditional) |
| ldpg_req | input | 1 | Load page constant into page buffer |
| jump_field | input | 6 | Branch/call target within a page |
| page_const | input | 4 | Page constant for load-page |
| cond_clr | input | 1 | Clear request for the condition flag |
| pc | output | 6 | Current program counter |
| page | output | 4 | Current page |

## Verification
The case that is hardest to bring about is a call made inside a call. It needs a load-page, a call while the condition flag is one, and a second call before any return, with no clear request arriving at the wrong moment. The damage only shows later, when the return fetches its page from the corrupted buffer. The bench first walks this sequence directly and then checks the bad return page. After that it runs a long pseudo-random strobe sweep weighted towards calls, so that nested calls, returns with no call active, and calls blocked by a cleared flag come up many times. Every cycle is compared against an arithmetic model in the bench.

// File: rtl/cr_seq_pkg.sv
package cr_seq_pkg;
  parameter int PC_W = 6;
  parameter int PG_W = 4;

  typedef struct packed {
    logic ret;
    logic call;
    logic br;
  } seq_go_t;
endpackage

// File: rtl/cr_cond_flag.sv
module cr_cond_flag (
  input  logic clk,
  input  logic rst,
  input  logic clr_req,
  output logic cond
);
  always_ff @(posedge clk) begin
    if (rst) cond <= 1'b1;
    else     cond <= ~clr_req;
  end

  p_flag_drop_r3: assert property (@(posedge clk) disable iff (rst)
    clr_req |=> !cond);
  p_flag_recover_r3: assert property (@(posedge clk) disable iff (rst)
    (!cond && !clr_req) |=> cond);
endmodule

// File: rtl/cr_pc_unit.sv
module cr_pc_unit
  import cr_seq_pkg::*;
#(
  parameter int AW = PC_W
) (
  input  logic          clk,
  input  logic          rst,
  input  seq_go_t       go,
  input  logic          call_busy,
  input  logic [AW-1:0] target,
  output logic [AW-1:0] pc,
  output logic [AW-1:0] ret_addr
);
  localparam logic [AW-1:0] ONE = AW'(1);

  logic [AW-1:0] pc_inc;
  assign pc_inc = pc + ONE;

  always_ff @(posedge clk) begin
    if (rst) begin
      pc       <= '0;
      ret_addr <= '0;
    end else begin
      if (go.ret)                pc <= ret_addr;
      else if (go.call || go.br) pc <= target;
      else                       pc <= pc_inc;
      if (go.call && !call_busy) ret_addr <= pc_inc;
    end
  end

  p_pc_step_r2: assert property (@(posedge clk) disable iff (rst)
    !(go.ret || go.call || go.br) |=> pc == $past(pc) + ONE);
  p_ret_pc_r8: assert property (@(posedge clk) disable iff (rst)
    go.ret |=> pc == $past(ret_addr));
  p_nested_keep_ret_r9: assert property (@(posedge clk) disable iff (rst)
    (go.call && call_busy) |=> $stable(ret_addr));
endmodule

// File: rtl/cr_page_unit.sv
module cr_page_unit
  import cr_seq_pkg::*;
#(
  parameter int GW = PG_W
) (
  input  logic          clk,
  input  logic          rst,
  input  seq_go_t       go,
  input  logic          ldpg,
  input  logic [GW-1:0] konst,
  output logic [GW-1:0] cur_pg,
  output logic [GW-1:0] buf_pg,
  output logic          call_busy
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cur_pg    <= '0;
      buf_pg    <= '0;
      call_busy <= 1'b0;
    end else begin
      if (go.ret) begin
        cur_pg    <= buf_pg;
        call_busy <= 1'b0;
      end else if (go.call) begin
        buf_pg <= cur_pg;
        if (!call_busy) begin
          cur_pg    <= buf_pg;
          call_busy <= 1'b1;
        end
      end else if (go.br && !call_busy) begin
        cur_pg <= buf_pg;
      end
      if (ldpg && !go.call) buf_pg <= konst;
    end
  end

  p_ret_clears_r8: assert property (@(posedge clk) disable iff (rst)
    go.ret |=> !call_busy);
  p_call_swap_r7: assert property (@(posedge clk) disable iff (rst)
    (go.call && !call_busy) |=> (cur_pg == $past(buf_pg)) && (buf_pg == $past(cur_pg)) && call_busy);
  p_nested_r9: assert property (@(posedge clk) disable iff (rst)
    (go.call && call_busy) |=> $stable(cur_pg) && (buf_pg == $past(cur_pg)));
  p_ldpg_only_r10: assert property (@(posedge clk) disable iff (rst)
    (ldpg && !go.call && !go.ret && !go.br) |=> $stable(cur_pg) && (buf_pg == $past(konst)));
endmodule

// File: rtl/cr_page_seq.sv
module cr_page_seq
  import cr_seq_pkg::*;
#(
  parameter int AW = PC_W,
  parameter int GW = PG_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          br_req,
  input  logic          call_req,
  input  logic          ret_req,
  input  logic          ldpg_req,
  input  logic [AW-1:0] jump_field,
  input  logic [GW-1:0] page_const,
  input  logic          cond_clr,
  output logic [AW-1:0] pc,
  output logic [GW-1:0] page
);
  logic          cond;
  logic          call_busy;
  logic [GW-1:0] buf_pg;
  logic [AW-1:0] ret_addr;
  seq_go_t       go;

  // priority: return, then call, then branch; call/branch need the flag
  always_comb begin
    go.ret  = ret_req;
    go.call = call_req && cond && !ret_req;
    go.br   = br_req && cond && !ret_req && !call_req;
  end

  cr_cond_flag u_flag (
    .clk(clk), .rst(rst), .clr_req(cond_clr), .cond(cond)
  );

  cr_pc_unit #(.AW(AW)) u_pc (
    .clk(clk), .rst(rst), .go(go), .call_busy(call_busy),
    .target(jump_field), .pc(pc), .ret_addr(ret_addr)
  );

  cr_page_unit #(.GW(GW)) u_page (
    .clk(clk), .rst(rst), .go(go), .ldpg(ldpg_req), .konst(page_const),
    .cur_pg(page), .buf_pg(buf_pg), .call_busy(call_busy)
  );

  p_one_taken_r11: assert property (@(posedge clk) disable iff (rst)
    $countones({go.ret, go.call, go.br}) <= 1);
  p_blocked_r4: assert property (@(posedge clk) disable iff (rst)
    (!cond && !ret_req) |=> pc == $past(pc) + AW'(1) && $stable(page));
endmodule

// File: tb/cr_page_seq_tb.sv
module cr_page_seq_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       br_req = 0, call_req = 0, ret_req = 0, ldpg_req = 0, cond_clr = 0;
  logic [5:0] jump_field = '0;
  logic [3:0] page_const = '0;
  logic [5:0] pc;
  logic [3:0] page;

  int checks = 0;
  int failures = 0;

  // reference state
  logic [5:0] m_pc, m_sr;
  logic [3:0] m_pa, m_pb;
  logic       m_cl, m_st;
  logic [31:0] rng = 32'h1234_5678;

  always #(CLK_PERIOD/2) clk = ~clk;

  cr_page_seq dut_i (
    .clk(clk), .rst(rst), .br_req(br_req), .call_req(call_req),
    .ret_req(ret_req), .ldpg_req(ldpg_req), .jump_field(jump_field),
    .page_const(page_const), .cond_clr(cond_clr), .pc(pc), .page(page)
  );

  task automatic check(string tag, logic [5:0] apc, logic [5:0] epc,
                       logic [3:0] apg, logic [3:0] epg);
    checks += 2;
    if (apc !== epc) begin
      failures++;
      $display("FAIL %s pc actual=%0d expected=%0d", tag, apc, epc);
    end
    if (apg !== epg) begin
      failures++;
      $display("FAIL %s page actual=%0d expected=%0d", tag, apg, epg);
    end
  endtask

  task automatic step(logic r, logic c, logic b, logic l, logic [3:0] k,
                      logic [5:0] a, logic clr);
    logic gr, gc, gb;
    string tag;
    ret_req = r; call_req = c; br_req = b; ldpg_req = l;
    page_const = k; jump_field = a; cond_clr = clr;
    gr = r;
    gc = c && m_st && !r;
    gb = b && m_st && !r && !c;
    if (gr && (c || b)) tag = "R11";
    else if (c && b && m_st) tag = "R11";
    else if (gr) tag = "R8";
    else if (gc && !m_cl) tag = "R7";
    else if (gc) tag = "R9";
    else if (gb && !m_cl) tag = "R5";
    else if (gb) tag = "R6";
    else if (c || b) tag = "R4";
    else if (l) tag = "R10";
    else tag = "R2";
    if (gc && !m_cl) m_sr = m_pc + 6'd1;
    if (gr) m_pc = m_sr;
    else if (gc || gb) m_pc = a;
    else m_pc = m_pc + 6'd1;
    if (gr) begin
      m_pa = m_pb; m_cl = 0;
      if (l) m_pb = k;
    end else if (gc) begin
      if (!m_cl) begin
        {m_pa, m_pb} = {m_pb, m_pa}; m_cl = 1;
      end else m_pb = m_pa;
    end else begin
      if (gb && !m_cl) m_pa = m_pb;
      if (l) m_pb = k;
    end
    m_st = !clr;
    @(posedge clk);
    @(negedge clk);
    check(tag, pc, m_pc, page, m_pa);
  endtask

  task automatic idle();
    step(0, 0, 0, 0, 4'd0, 6'd0, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    m_pc = 0; m_sr = 0; m_pa = 0; m_pb = 0; m_cl = 0; m_st = 1;
    repeat (3) @(negedge clk);
    rst = 0;
    check("R1", pc, 6'd0, page, 4'd0);

    // R3 / R4: clear, blocked branch, then flag recovers
    step(0, 0, 0, 0, 0, 6'd0, 1);
    step(0, 0, 1, 0, 0, 6'd40, 0);  // R3: blocked, pc advances
    step(0, 0, 1, 0, 0, 6'd40, 0);  // R3: flag back to one, branch taken
    // R2 wrap
    step(0, 0, 1, 0, 0, 6'd62, 0);
    idle(); idle();                 // R2: 63 then 0
    // R10 then R5
    step(0, 0, 0, 1, 4'd5, 6'd0, 0);
    step(0, 0, 1, 0, 0, 6'd10, 0);  // R5: page 5, pc 10
    // R7 first call, R9 nested, R8 return into corrupted page
    step(0, 0, 0, 1, 4'd9, 6'd0, 0);
    step(0, 1, 0, 0, 0, 6'd20, 0);  // R7: page 9, buffer 5
    step(0, 0, 1, 0, 0, 6'd25, 0);  // R6: page stays 9
    step(0, 1, 0, 0, 0, 6'd30, 0);  // R9: buffer becomes 9
    step(1, 0, 0, 0, 0, 6'd0, 0);   // R8: pc 12, page 9 (not 5)
    // R10 ignored during taken call; R11 priority
    step(0, 1, 0, 1, 4'd7, 6'd3, 0);
    step(1, 1, 1, 0, 0, 6'd50, 0);  // R11
    step(0, 1, 1, 0, 0, 6'd44, 0);  // R11
    step(1, 0, 0, 0, 0, 6'd0, 1);   // R8
    step(1, 0, 0, 0, 0, 6'd0, 0);   // R8 with flag zero

    // pseudo-random sweep weighted towards calls
    for (int i = 0; i < 4000; i++) begin
      rng = rng ^ (rng << 13); rng = rng ^ (rng >> 17); rng = rng ^ (rng << 5);
      step(rng[2:0] == 3'd0, rng[4:3] == 2'd0, rng[6:5] == 2'd0,
           rng[7], rng[11:8], rng[17:12], rng[20:18] == 3'd0);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule